// File: doc/BRIEF.md
# Banked Extended Sequencer Register File

This block holds the extended configuration registers reached through a VGA-style sequencer index/data port pair. The host first writes an index, then reads or writes the data port. Index 0Bh is a read-only version register with a side effect: reading it switches indices 0Dh and 0Eh to the "new" register set, and writing it switches them back to the "old" set. Each set has its own storage, so a value kept in one set survives while the other set is in use.

Decoded control fields come straight out of the stored registers. These are the emulation mode, paging, DRAM clock and 16-bit video enables, the 128 KB and 64 KB bank numbers, and the power-up configuration fields at index 0Fh. The block also builds the byte address of the display start. It takes a 16-bit CRTC start value, an extension bit 16 and old-set 0Eh bit 0 as bit 17. It then scales that value to 8-byte units when paging is on and to 4-byte units when paging is off.

Top module: `seq_ext_regs`

## Requirements
- R1: After reset the set selector is old (`new_set`=0), every decoded output is zero, and data reads of indices 0Dh, 0Eh and 0Fh return 00h.
- R2: A data read at index 0Bh returns 02h. From the next cycle `new_set` is 1.
- R3: A data write at index 0Bh clears `new_set` from the next cycle. The written byte changes no stored register.
- R4: In the old set, index 0Dh is stored as written and reads back unchanged. `emu_mode` is bits 2:0 (0 VGA, 3 EGA, 5 CGA/MDA/Hercules), `paging_en` is bit 4 and `dram_clk_en` is bit 5.
- R5: In the old set, index 0Eh is stored as written and reads back unchanged. `bank128` is bits 2:1 and `video16_en` is bit 3.
- R6: In the new set, a write of D to index 0Eh makes `bank64` equal D[3:0] XOR 2h. A read returns {D[7], 000b, `bank64`}, so bits 6:4 always read zero.
- R7: Index 0Fh is stored as written and reads back unchanged. `sw_cfg` is bits 3:0, `bus_type` is bit 4, `io_hi` is bit 5 (3xxh base), `rom_en` is bit 6 and `rom16_en` is bit 7.
- R8: The two sets hold separate storage. While `new_set` is 1, writes to 0Dh/0Eh leave the old-set outputs unchanged, and the old values read back after a return to the old set.
- R9: `start_addr` = {old 0Eh bit 0, `start_hi`, `crtc_start`} shifted left by 3 when `paging_en` is 1, and shifted left by 2 otherwise.
- R10: A data read at any index other than 0Bh, 0Dh, 0Eh or 0Fh returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Write `wdata` into the index register |
| data_we | input | 1 | Write `wdata` to the indexed register |
| data_re | input | 1 | Data read strobe (triggers the 0Bh side effect) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Indexed register value |
| crtc_start | input | 16 | CRTC display start value |
| start_hi | input | 1 | Display start extension bit 16 |
| new_set | output | 1 | 1 when 0Dh/0Eh decode to the new set |
| emu_mode | output | 3 | Emulation mode |
| paging_en | output | 1 | Paging enable |
| dram_clk_en | output | 1 | DRAM clock enable |
| bank128 | output | 2 | 128 KB bank number |
| video16_en | output | 1 | 16-bit video interface enable |
| bank64 | output | 4 | Effective 64 KB bank number |
| sw_cfg | output | 4 | Switch settings |
| bus_type | output | 1 | Bus type |
| io_hi | output | 1 | I/O base at 3xxh when set |
| rom_en | output | 1 | On-card ROM enable |
| rom16_en | output | 1 | 16-bit ROM access enable |
| start_addr | output | 21 | Display start byte address |

## Verification
The bench toggles the set selector several times. It checks that a read of 0Bh, and not merely selecting the index, flips the decode. A design that latched the side effect on the index write, or ignored the read strobe, would return the wrong set for 0Dh. New-set 0Eh is written with values whose low nibble makes the XOR visible and whose bits 6:4 are set. A missing inversion, an inversion applied on readback, or reserved bits stored would each show a wrong readback or a wrong `bank64`. Writing in one set and then reading the other catches shared storage. The display start is checked with the extra high bit set, both with and without paging, so a wrong shift or a dropped bit 17 would show as a different address.

// File: rtl/seq_ext_regs.sv
module seq_ext_regs #(
  parameter int        START_W = 16,
  parameter logic [7:0] IDX_VER = 8'h0B,
  parameter logic [7:0] IDX_MC2 = 8'h0D,
  parameter logic [7:0] IDX_MC1 = 8'h0E,
  parameter logic [7:0] IDX_PWR = 8'h0F,
  parameter logic [7:0] CHIP_ID = 8'h02,
  parameter logic [3:0] BANK_XOR = 4'h2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_we,
  input  logic                 data_we,
  input  logic                 data_re,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [START_W-1:0]   crtc_start,
  input  logic                 start_hi,
  output logic                 new_set,
  output logic [2:0]           emu_mode,
  output logic                 paging_en,
  output logic                 dram_clk_en,
  output logic [1:0]           bank128,
  output logic                 video16_en,
  output logic [3:0]           bank64,
  output logic [3:0]           sw_cfg,
  output logic                 bus_type,
  output logic                 io_hi,
  output logic                 rom_en,
  output logic                 rom16_en,
  output logic [START_W+4:0]   start_addr
);
  localparam int ASM_W = START_W + 2;

  logic [7:0] idx_q;
  logic [7:0] old_mc2, old_mc1, new_mc2, pwr_q;
  logic [3:0] new_bank;
  logic       new_b7;
  logic       sel_q;
  logic [ASM_W-1:0] asm_start;

  wire wr_ver = data_we && idx_q == IDX_VER;
  wire rd_ver = data_re && idx_q == IDX_VER;
  wire wr_mc2 = data_we && idx_q == IDX_MC2;
  wire wr_mc1 = data_we && idx_q == IDX_MC1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      sel_q    <= 1'b0;
      old_mc2  <= '0;
      old_mc1  <= '0;
      new_mc2  <= '0;
      new_bank <= '0;
      new_b7   <= 1'b0;
      pwr_q    <= '0;
    end else begin
      if (idx_we) idx_q <= wdata;
      if (wr_ver) sel_q <= 1'b0;
      else if (rd_ver) sel_q <= 1'b1;
      if (wr_mc2) begin
        if (sel_q) new_mc2 <= wdata;
        else       old_mc2 <= wdata;
      end
      if (wr_mc1) begin
        if (sel_q) begin
          new_bank <= wdata[3:0] ^ BANK_XOR;
          new_b7   <= wdata[7];
        end else begin
          old_mc1  <= wdata;
        end
      end
      if (data_we && idx_q == IDX_PWR) pwr_q <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (idx_q == IDX_VER)      rdata = CHIP_ID;
    else if (idx_q == IDX_MC2) rdata = sel_q ? new_mc2 : old_mc2;
    else if (idx_q == IDX_MC1) rdata = sel_q ? {new_b7, 3'b000, new_bank} : old_mc1;
    else if (idx_q == IDX_PWR) rdata = pwr_q;
  end

  assign new_set     = sel_q;
  assign emu_mode    = old_mc2[2:0];
  assign paging_en   = old_mc2[4];
  assign dram_clk_en = old_mc2[5];
  assign bank128     = old_mc1[2:1];
  assign video16_en  = old_mc1[3];
  assign bank64      = new_bank;
  assign sw_cfg      = pwr_q[3:0];
  assign bus_type    = pwr_q[4];
  assign io_hi       = pwr_q[5];
  assign rom_en      = pwr_q[6];
  assign rom16_en    = pwr_q[7];

  assign asm_start  = {old_mc1[0], start_hi, crtc_start};
  assign start_addr = paging_en ? {asm_start, 3'b000} : {1'b0, asm_start, 2'b00};

  AST_VER_READ_SETS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && !data_we && idx_q == IDX_VER) |=> new_set); // R2
  AST_VER_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_VER) |-> rdata == CHIP_ID); // R2
  AST_VER_WRITE_SETS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx_q == IDX_VER) |=> !new_set); // R3
  AST_BANK64_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && new_set && idx_q == IDX_MC1) |=> bank64 == ($past(wdata[3:0]) ^ BANK_XOR)); // R6
  AST_NEW_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (new_set && idx_q == IDX_MC1) |-> rdata[6:4] == 3'b000); // R6
  AST_PWR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_we && idx_q == IDX_PWR) |=> $stable(pwr_q)); // R7
  AST_OLD_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (new_set && !idx_we) |=> $stable({emu_mode, paging_en, dram_clk_en, bank128, video16_en})); // R8
  AST_START_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    paging_en |-> start_addr[2:0] == 3'b000); // R9
endmodule

// File: tb/seq_ext_regs_test.sv
module seq_ext_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] crtc_start = '0;
  logic        start_hi = 1'b0;
  logic        new_set, paging_en, dram_clk_en, video16_en;
  logic        bus_type, io_hi, rom_en, rom16_en;
  logic [2:0]  emu_mode;
  logic [1:0]  bank128;
  logic [3:0]  bank64, sw_cfg;
  logic [20:0] start_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  seq_ext_regs uut (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we), .data_re(data_re),
    .wdata(wdata), .rdata(rdata), .crtc_start(crtc_start), .start_hi(start_hi),
    .new_set(new_set), .emu_mode(emu_mode), .paging_en(paging_en),
    .dram_clk_en(dram_clk_en), .bank128(bank128), .video16_en(video16_en),
    .bank64(bank64), .sw_cfg(sw_cfg), .bus_type(bus_type), .io_hi(io_hi),
    .rom_en(rom_en), .rom16_en(rom16_en), .start_addr(start_addr)
  );

  always @(negedge clk) begin
    if (data_re && q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s read: actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(logic [7:0] i);
    @(posedge clk); #1;
    idx_we = 1'b1; wdata = i;
    @(posedge clk); #1;
    idx_we = 1'b0;
  endtask

  task automatic wr(logic [7:0] i, logic [7:0] d);
    set_idx(i);
    data_we = 1'b1; wdata = d;
    @(posedge clk); #1;
    data_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] i, logic [7:0] exp, string tag);
    set_idx(i);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    data_re = 1'b1;
    @(posedge clk); #1;
    data_re = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 new_set", new_set, 0);
    chk("R1 outputs", {emu_mode, paging_en, dram_clk_en, bank128, video16_en, bank64,
                       sw_cfg, bus_type, io_hi, rom_en, rom16_en}, 0);
    rd(8'h0D, 8'h00, "R1 0Dh");
    rd(8'h0E, 8'h00, "R1 0Eh");
    rd(8'h0F, 8'h00, "R1 0Fh");

    rd(8'h0B, 8'h02, "R2 version");
    @(negedge clk);
    chk("R2 new_set after read", new_set, 1);

    wr(8'h0E, 8'h05);
    @(negedge clk);
    chk("R6 bank64 xor", bank64, 4'h7);
    rd(8'h0E, 8'h07, "R6 readback");
    wr(8'h0E, 8'hF0);
    @(negedge clk);
    chk("R6 bank64 high write", bank64, 4'h2);
    rd(8'h0E, 8'h82, "R6 reserved zero");

    wr(8'h0D, 8'hAA);
    rd(8'h0D, 8'hAA, "R8 new 0Dh");
    @(negedge clk);
    chk("R8 old outputs untouched", {emu_mode, paging_en, dram_clk_en, bank128, video16_en}, 0);

    wr(8'h0B, 8'hFF);
    @(negedge clk);
    chk("R3 new_set after write", new_set, 0);
    chk("R3 bank64 kept", bank64, 4'h2);
    rd(8'h0D, 8'h00, "R8 old 0Dh separate");
    rd(8'h0B, 8'h02, "R3 version unchanged");
    wr(8'h0B, 8'h00);

    wr(8'h0D, 8'h35);
    @(negedge clk);
    chk("R4 emu_mode", emu_mode, 5);
    chk("R4 paging", paging_en, 1);
    chk("R4 dram clk", dram_clk_en, 1);
    rd(8'h0D, 8'h35, "R4 readback");

    wr(8'h0E, 8'h0F);
    @(negedge clk);
    chk("R5 bank128", bank128, 3);
    chk("R5 video16", video16_en, 1);
    rd(8'h0E, 8'h0F, "R5 readback");
    chk("R8 bank64 unaffected by old write", bank64, 4'h2);

    crtc_start = 16'h1234; start_hi = 1'b1;
    @(negedge clk);
    chk("R9 paged start", start_addr, 21'h1891A0);
    wr(8'h0D, 8'h05);
    @(negedge clk);
    chk("R9 unpaged start", start_addr, 21'h0C48D0);
    wr(8'h0E, 8'h0E);
    @(negedge clk);
    chk("R9 bit17 clear", start_addr, 21'h0448D0);

    wr(8'h0F, 8'hB6);
    @(negedge clk);
    chk("R7 sw_cfg", sw_cfg, 6);
    chk("R7 bits", {rom16_en, rom_en, io_hi, bus_type}, 4'b1011);
    rd(8'h0F, 8'hB6, "R7 readback");

    rd(8'h10, 8'h00, "R10 unmapped 10h");
    rd(8'h0C, 8'h00, "R10 unmapped 0Ch");

    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule